// File: doc/BRIEF.md
# Program Counter Address Fault Checker

This block sits next to the program counter of a small coprocessor whose code is addressed with 16 bits. Each cycle that an instruction completes (`step_i` high), it works out the next fetch address. For a sequential instruction that address is the current PC plus the instruction length. For a taken PC-relative jump it is the current PC plus a signed offset. The block then decides whether that address is legal. An address is illegal when it lies at or beyond the implemented code-memory size, or when the arithmetic leaves the unsigned 16-bit range in either direction.

A debug opcode issued while the core is not in debug mode is not executed. It is reported as an illegal operation. In debug mode the same opcode advances the PC like any sequential instruction. On any fault the PC stays on the faulting instruction. A one-cycle error pulse is raised, and a sticky cause bit is set. Software clears the cause bit by writing one to it.

Top module: `pcf_checker`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_o` is 0, `iae_o` and `iop_o` are 0, and `status_o` is 3'b000.
- R2: A completing instruction of class 2'b00 or 2'b11 (sequential) that does not fault sets `pc_o` to the old PC plus `len_i` in the next cycle.
- R3: A completing instruction of class 2'b01 (taken relative jump) that does not fault sets `pc_o` to the old PC plus the sign-extended `off_i`.
- R4: If the unwrapped next address is at or above `cmem_size_i` and the 16-bit range is not left, `iae_o` pulses, `status_o[0]` (range cause) is set and `pc_o` holds. An address one below the size is accepted.
- R5: A sequential step whose sum exceeds 16'hFFFF raises `iae_o` and sets `status_o[1]` (wrap cause) with `pc_o` held, even when the wrapped value would fall inside code memory.
- R6: A relative jump whose result passes above 16'hFFFF or below 0 is treated as in R5.
- R7: A faulting instruction produces exactly one single-cycle pulse. When a wrap also exceeds the size, only one `iae_o` pulse is raised and only the wrap cause (bit 1) is recorded.
- R8: Class 2'b10 (debug opcode) with `dbg_mode_i` low raises `iop_o` and sets `status_o[2]`. It holds `pc_o` and raises no `iae_o`, even if its address would fault.
- R9: Class 2'b10 with `dbg_mode_i` high behaves as a sequential instruction and raises no `iop_o`.
- R10: Each `status_o` bit stays set until a cycle with the matching `clr_i` bit high. A new fault on the same bit in that cycle wins over the clear.
- R11: With `step_i` low, `pc_o`, `status_o` and the pulses are unaffected by the other inputs. The only exception is `clr_i`.
- R12: `iae_o` and `iop_o` are high only in the cycle that follows a faulting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Current instruction completes this cycle |
| cls_i | input | 2 | Class: 00 sequential, 01 relative jump taken, 10 debug opcode, 11 sequential |
| len_i | input | LEN_W (3) | Instruction length in bytes |
| off_i | input | OFF_W (16) | Signed jump offset |
| dbg_mode_i | input | 1 | Core is in debug mode |
| cmem_size_i | input | PC_W+1 (17) | Implemented code-memory size in bytes |
| clr_i | input | 3 | Write-one-to-clear mask for status |
| pc_o | output | PC_W (16) | Program counter |
| iae_o | output | 1 | Instruction address error pulse |
| iop_o | output | 1 | Illegal operation error pulse |
| status_o | output | 3 | Sticky cause: bit0 range, bit1 wrap, bit2 illegal op |

## Verification
The bench builds the block with its default parameters: a 16-bit PC, 3-bit length and 16-bit offset. Because the code-memory size is an input, the bench can switch it between 16'h1000 and the full 17'h10000. The smaller size lets the range fault be reached at the exact boundary. The full size makes range faults impossible, so a wrap can be seen on its own. Walking the PC with jumps of 16'h7FFC reaches both ends of the address space. That makes forward and backward wrap reachable from a few steps.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  typedef enum logic [1:0] {
    CLS_SEQ     = 2'b00,
    CLS_JMP     = 2'b01,
    CLS_DBG     = 2'b10,
    CLS_SEQ_ALT = 2'b11
  } instr_cls_e;

  localparam int ST_RANGE = 0;
  localparam int ST_WRAP  = 1;
  localparam int ST_ILLOP = 2;
  localparam int ST_W     = 3;
endpackage

// File: rtl/pcf_next_addr.sv
module pcf_next_addr #(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             is_jmp_i,
  output logic [PC_W:0]    sum_o,
  output logic             wrap_o
);
  // one guard bit above the carry so a backward jump shows up as negative
  localparam int SUM_W = PC_W + 2;

  logic signed [SUM_W-1:0] base, delta, res;

  generate
    if (OFF_W < SUM_W) begin : g_off_ext
      always_comb begin
        base  = signed'({2'b00, pc_i});
        delta = is_jmp_i ? signed'({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i})
                         : signed'({{(SUM_W-LEN_W){1'b0}}, len_i});
      end
    end else begin : g_off_trunc
      always_comb begin
        base  = signed'({2'b00, pc_i});
        delta = is_jmp_i ? signed'(off_i[SUM_W-1:0])
                         : signed'({{(SUM_W-LEN_W){1'b0}}, len_i});
      end
    end
  endgenerate

  always_comb begin
    res    = base + delta;
    sum_o  = res[PC_W:0];
    wrap_o = res[SUM_W-1] | res[PC_W];
  end
endmodule

// File: rtl/pcf_range_chk.sv
module pcf_range_chk #(
  parameter int PC_W = 16
) (
  input  logic [PC_W:0] sum_i,
  input  logic [PC_W:0] size_i,
  input  logic          wrap_i,
  output logic          oor_o
);
  // wrap has priority: a wrapped address reports only the wrap cause
  always_comb oor_o = !wrap_i && (sum_i >= size_i);
endmodule

// File: rtl/pcf_fault_ctrl.sv
module pcf_fault_ctrl
  import pcf_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [1:0]      cls_i,
  input  logic            dbg_mode_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic [PC_W:0]   next_i,
  input  logic            wrap_i,
  input  logic            oor_i,
  output logic [PC_W-1:0] pc_o,
  output logic            iae_o,
  output logic            iop_o,
  output logic [ST_W-1:0] status_o
);
  instr_cls_e      cls;
  logic            illop, addr_flt, fault;
  logic [ST_W-1:0] st_set, st_d, status_q;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            iae_q, iop_q;

  always_comb begin
    cls      = instr_cls_e'(cls_i);
    illop    = step_i && (cls == CLS_DBG) && !dbg_mode_i;
    addr_flt = step_i && !illop && (wrap_i || oor_i);
    fault    = illop || addr_flt;
    pc_d     = (step_i && !fault) ? next_i[PC_W-1:0] : pc_q;
    st_set           = '0;
    st_set[ST_RANGE] = addr_flt && !wrap_i;
    st_set[ST_WRAP]  = addr_flt && wrap_i;
    st_set[ST_ILLOP] = illop;
    st_d = (status_q & ~clr_i) | st_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      iae_q    <= 1'b0;
      iop_q    <= 1'b0;
      status_q <= '0;
    end else begin
      pc_q     <= pc_d;
      iae_q    <= addr_flt;
      iop_q    <= illop;
      status_q <= st_d;
    end
  end

  assign pc_o     = pc_q;
  assign iae_o    = iae_q;
  assign iop_o    = iop_q;
  assign status_o = status_q;

  p_hold_on_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (wrap_i || oor_i || (cls_i == CLS_DBG && !dbg_mode_i)))
      |=> (pc_q == $past(pc_q)));

  p_wrap_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wrap_i && cls_i != CLS_DBG) |=> (iae_q && status_q[ST_WRAP]));

  p_illop_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cls_i == CLS_DBG && !dbg_mode_i) |=> (iop_q && !iae_q));

  p_one_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iae_q |-> !iop_q);

  p_idle_pc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(pc_q) && !iae_q && !iop_q));

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[ST_RANGE] && !clr_i[ST_RANGE]) |=> status_q[ST_RANGE]);
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker
  import pcf_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3,
  parameter int OFF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [1:0]       cls_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             dbg_mode_i,
  input  logic [PC_W:0]    cmem_size_i,
  input  logic [ST_W-1:0]  clr_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             iae_o,
  output logic             iop_o,
  output logic [ST_W-1:0]  status_o
);
  logic [PC_W:0] sum;
  logic          wrap, oor, is_jmp;

  assign is_jmp = (cls_i == CLS_JMP);

  pcf_next_addr #(.PC_W(PC_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_next (
    .pc_i     (pc_o),
    .len_i    (len_i),
    .off_i    (off_i),
    .is_jmp_i (is_jmp),
    .sum_o    (sum),
    .wrap_o   (wrap)
  );

  pcf_range_chk #(.PC_W(PC_W)) u_range (
    .sum_i  (sum),
    .size_i (cmem_size_i),
    .wrap_i (wrap),
    .oor_o  (oor)
  );

  pcf_fault_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .cls_i      (cls_i),
    .dbg_mode_i (dbg_mode_i),
    .clr_i      (clr_i),
    .next_i     (sum),
    .wrap_i     (wrap),
    .oor_i      (oor),
    .pc_o       (pc_o),
    .iae_o      (iae_o),
    .iop_o      (iop_o),
    .status_o   (status_o)
  );
endmodule

// File: tb/pcf_checker_tb.sv
module pcf_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [1:0]  cls = 2'b00;
  logic [2:0]  len = 3'd0;
  logic [15:0] off = 16'h0;
  logic        dbg = 1'b0;
  logic [16:0] size = 17'h01000;
  logic [2:0]  clr = 3'b000;
  logic [15:0] pc;
  logic        iae, iop;
  logic [2:0]  st;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pcf_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .cls_i(cls), .len_i(len),
    .off_i(off), .dbg_mode_i(dbg), .cmem_size_i(size), .clr_i(clr),
    .pc_o(pc), .iae_o(iae), .iop_o(iop), .status_o(st)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step = 1'b0; clr = 3'b000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one completing instruction, then one idle cycle checking the pulse dropped
  task automatic do_step(input string req, input logic [1:0] c, input logic [2:0] l,
                         input logic [15:0] o, input logic d, input logic [2:0] cl,
                         input int e_pc, input int e_iae, input int e_iop, input int e_st);
    cls = c; len = l; off = o; dbg = d; clr = cl; step = 1'b1;
    @(negedge clk);
    step = 1'b0; clr = 3'b000;
    chk(req, "pc", pc, e_pc);
    chk(req, "iae", iae, e_iae);
    chk(req, "iop", iop, e_iop);
    chk(req, "status", st, e_st);
    @(negedge clk);
    chk("R12", "iae drop", iae, 0);
    chk("R12", "iop drop", iop, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pc in reset", pc, 0);
    chk("R1", "status in reset", st, 0);
    do_reset();
    chk("R1", "pc", pc, 0);
    chk("R1", "iae", iae, 0);
    chk("R1", "iop", iop, 0);
    chk("R1", "status", st, 0);
  endtask

  task automatic t_seq_jump();
    size = 17'h01000;
    do_step("R2", 2'b00, 3'd2, 16'h0, 1'b0, 3'b0, 16'h0002, 0, 0, 0);
    do_step("R2", 2'b00, 3'd4, 16'h0, 1'b0, 3'b0, 16'h0006, 0, 0, 0);
    do_step("R2", 2'b11, 3'd2, 16'h0, 1'b0, 3'b0, 16'h0008, 0, 0, 0);
    do_step("R3", 2'b01, 3'd2, 16'h0100, 1'b0, 3'b0, 16'h0108, 0, 0, 0);
    do_step("R3", 2'b01, 3'd2, 16'hFFF8, 1'b0, 3'b0, 16'h0100, 0, 0, 0);
  endtask

  task automatic t_idle();
    cls = 2'b01; off = 16'h0040; len = 3'd4; step = 1'b0;
    size = 17'h00004;
    repeat (3) @(negedge clk);
    chk("R11", "pc idle", pc, 16'h0100);
    chk("R11", "iae idle", iae, 0);
    chk("R11", "status idle", st, 0);
    size = 17'h01000;
  endtask

  task automatic t_range();
    do_step("R4", 2'b01, 3'd2, 16'h0F00, 1'b0, 3'b0, 16'h0100, 1, 0, 3'b001);
    do_step("R4", 2'b01, 3'd2, 16'h0EFE, 1'b0, 3'b0, 16'h0FFE, 0, 0, 3'b001);
    do_step("R7", 2'b00, 3'd2, 16'h0, 1'b0, 3'b0, 16'h0FFE, 1, 0, 3'b001);
  endtask

  task automatic t_clear();
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
    chk("R10", "status cleared", st, 0);
    do_step("R10", 2'b00, 3'd2, 16'h0, 1'b0, 3'b001, 16'h0FFE, 1, 0, 3'b001);
    @(negedge clk);
    chk("R10", "status sticky", st, 3'b001);
    clr = 3'b001;
    @(negedge clk);
    clr = 3'b000;
  endtask

  task automatic t_wrap();
    do_reset();
    size = 17'h10000;
    do_step("R3", 2'b01, 3'd2, 16'h7FFC, 1'b0, 3'b0, 16'h7FFC, 0, 0, 0);
    do_step("R3", 2'b01, 3'd2, 16'h7FFC, 1'b0, 3'b0, 16'hFFF8, 0, 0, 0);
    do_step("R2", 2'b00, 3'd4, 16'h0, 1'b0, 3'b0, 16'hFFFC, 0, 0, 0);
    do_step("R5", 2'b00, 3'd4, 16'h0, 1'b0, 3'b0, 16'hFFFC, 1, 0, 3'b010);
    do_step("R6", 2'b01, 3'd2, 16'h0008, 1'b0, 3'b010, 16'hFFFC, 1, 0, 3'b010);
    clr = 3'b010;
    @(negedge clk);
    clr = 3'b000;
    do_step("R3", 2'b01, 3'd2, 16'h8004, 1'b0, 3'b0, 16'h8000, 0, 0, 0);
    do_step("R3", 2'b01, 3'd2, 16'h8004, 1'b0, 3'b0, 16'h0004, 0, 0, 0);
    size = 17'h01000;
    do_step("R7", 2'b01, 3'd2, 16'hFFF8, 1'b0, 3'b0, 16'h0004, 1, 0, 3'b010);
  endtask

  task automatic t_debug();
    do_reset();
    size = 17'h00002;
    do_step("R8", 2'b10, 3'd4, 16'h0, 1'b0, 3'b0, 16'h0000, 0, 1, 3'b100);
    size = 17'h01000;
    do_step("R9", 2'b10, 3'd2, 16'h0, 1'b1, 3'b100, 16'h0002, 0, 0, 3'b000);
  endtask

  initial begin
    t_reset();
    t_seq_jump();
    t_idle();
    t_range();
    t_clear();
    t_wrap();
    t_debug();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule